// File: doc/BRIEF.md
# Loop Buffer Fill and Control Sequencer

This controller sits between an L1 instruction memory and a datapath and manages a small instruction buffer for loops. Software opens buffer mode with a dedicated start command. The command carries the address of the start instruction and an offset. The loop window runs from the instruction after the command up to that start address plus the offset. The controller copies the window from L1 into the buffer one word per accepted L1 access. While it copies, the core stalls; the core sees this on the mode output. Once the copy is complete, every fetch that falls inside the window is served from the buffer and no L1 request is issued.

The fetch address is the taken-branch target when a branch is taken and the current PC otherwise. The window is therefore checked against both sequential flow and branches. A branch that lands inside the window, such as an if/else path in the loop body, keeps the controller in buffer mode. The first fetch that falls outside the window ends buffer mode. In that cycle nothing is fetched. In the next cycle the L1 serves the PC that the core is still holding, and the window registers are cleared.

The buffer memory itself lies outside the block. The controller drives its write and read strobes, and the core selects its instruction source from the mode output.

Top module: `lbuf_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, mode_o reads 0 (normal mode), buf_we_o and buf_re_o are low, and l1_req_o is low when core_fetch_i is low.
- R2: In normal mode (mode_o = 0), l1_req_o equals core_fetch_i in the same cycle, buf_re_o is low, and l1_addr_o is br_target_i when br_taken_i is high and pc_i otherwise.
- R3: A start command (lbon_i high) accepted in normal mode makes mode_o read 1 (filling) in the next cycle. The window starts at lbon_addr_i + 1 and ends at lbon_addr_i + 1 + lbon_offset_i.
- R4: While filling, l1_req_o is high and l1_addr_o is start + k, where k is the number of entries written so far. In each cycle with l1_ack_i high, buf_we_o is high, buf_waddr_o = k and buf_wdata_o = l1_rdata_i.
- R5: A filling cycle with l1_ack_i low is a wait state. It writes nothing and presents the same L1 address again in the next cycle.
- R6: After entry number lbon_offset_i has been written, mode_o reads 2 (executing) in the next cycle. Offsets 0 and DEPTH-1 are both filled completely.
- R7: While executing, a fetch whose address lies between start and end, both ends included, raises buf_re_o with buf_raddr_o = fetch address - start, and keeps l1_req_o low, in the same cycle.
- R8: A taken branch whose target lies inside the window is read from the buffer at the target's index, and the controller stays in executing mode.
- R9: While executing, a fetch whose address is outside the window raises neither buf_re_o nor l1_req_o in that cycle. In the next cycle mode_o reads 0 and the L1 is requested at the held fetch address.
- R10: A start command with lbon_offset_i >= DEPTH, or one whose window would run past the top of the address space, is rejected, and mode_o stays 0.
- R11: A start command that arrives while filling or executing is ignored. Filling continues over the original window, and execution keeps the original window.
- R12: While executing, a cycle with core_fetch_i low raises neither buf_re_o nor l1_req_o and does not leave executing mode, whatever pc_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_fetch_i | input | 1 | Core wants an instruction this cycle |
| pc_i | input | AW | Sequential fetch PC |
| br_taken_i | input | 1 | Branch taken this cycle |
| br_target_i | input | AW | Branch target address |
| lbon_i | input | 1 | Start command decoded |
| lbon_addr_i | input | AW | Address of the start command |
| lbon_offset_i | input | PW+1 | Offset of the loop end from its first instruction |
| l1_req_o | output | 1 | L1 fetch request |
| l1_addr_o | output | AW | L1 fetch address |
| l1_ack_i | input | 1 | L1 data valid this cycle (low = wait state) |
| l1_rdata_i | input | IW | L1 instruction word |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_waddr_o | output | PW | Buffer write index |
| buf_wdata_o | output | IW | Buffer write data |
| buf_re_o | output | 1 | Buffer read strobe |
| buf_raddr_o | output | PW | Buffer read index |
| mode_o | output | 2 | 0 normal, 1 filling, 2 executing |

## Verification
The hardest cases to reach from the ports are the ones that interleave with a fill already under way. Examples are a second start command arriving in the middle of a copy, and an L1 wait state that lands on a chosen entry. The stimulus drives l1_ack_i with a repeating pattern that withholds every third cycle, and injects a competing start command in the second fill cycle. It then checks that every write index, address and data word still follows the first window. Window edges are reached with fetches exactly at start, at end and one past end, with branch targets just below start, and with loops of length 1 and DEPTH.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;

    localparam int unsigned LB_ADDR_W = 16;
    localparam int unsigned LB_INSN_W = 32;
    localparam int unsigned LB_DEPTH  = 128;

    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_FILL   = 2'd1,
        MODE_EXEC   = 2'd2
    } lb_mode_e;

    // Next phase of the sequencer from the three events that move it.
    function automatic lb_mode_e lb_next_mode(
        input lb_mode_e cur,
        input logic     accept,
        input logic     fill_done,
        input logic     leave
    );
        lb_mode_e nxt;
        nxt = cur;
        unique case (cur)
            MODE_NORMAL: if (accept)    nxt = MODE_FILL;
            MODE_FILL:   if (fill_done) nxt = MODE_EXEC;
            MODE_EXEC:   if (leave)     nxt = MODE_NORMAL;
            default:                    nxt = MODE_NORMAL;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/lbuf_window.sv
module lbuf_window #(
    parameter int unsigned AW    = 16,
    parameter int unsigned PW    = 7,
    parameter int unsigned OW    = 8,
    parameter int unsigned DEPTH = 128
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          clear_i,
    input  logic [AW-1:0] cmd_addr_i,
    input  logic [OW-1:0] cmd_off_i,
    input  logic [AW-1:0] fetch_addr_i,
    output logic          fits_o,
    output logic [AW-1:0] start_o,
    output logic [OW-1:0] span_o,
    output logic          in_win_o,
    output logic [PW-1:0] idx_o
);

    logic [AW-1:0] start_q, last_q;
    logic [OW-1:0] span_q;
    logic          valid_q;
    logic [AW:0]   top_sum;
    logic [AW-1:0] start_d;
    logic [AW-1:0] rel;

    // Last window address computed one bit wider to detect wrap past the top.
    assign top_sum = {1'b0, cmd_addr_i} + (AW+1)'(cmd_off_i) + (AW+1)'(1);
    assign start_d = cmd_addr_i + AW'(1);
    assign fits_o  = (cmd_off_i < OW'(DEPTH)) && !top_sum[AW];

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            start_q <= '0;
            last_q  <= '0;
            span_q  <= '0;
            valid_q <= 1'b0;
        end else if (load_i) begin
            start_q <= start_d;
            last_q  <= top_sum[AW-1:0];
            span_q  <= cmd_off_i;
            valid_q <= 1'b1;
        end
    end

    assign rel      = fetch_addr_i - start_q;
    assign in_win_o = valid_q && (fetch_addr_i >= start_q) && (fetch_addr_i <= last_q);
    assign idx_o    = rel[PW-1:0];
    assign start_o  = start_q;
    assign span_o   = span_q;

    AST_IDX_IN_SPAN: assert property (@(posedge clk) disable iff (rst)
        in_win_o |-> (OW'(idx_o) <= span_q)); // R7
    AST_WIN_HELD: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !clear_i) |=> ($stable(start_q) && $stable(last_q))); // R11

endmodule

// File: rtl/lbuf_filler.sv
module lbuf_filler #(
    parameter int unsigned AW = 16,
    parameter int unsigned IW = 32,
    parameter int unsigned PW = 7,
    parameter int unsigned OW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active_i,
    input  logic          restart_i,
    input  logic          ack_i,
    input  logic [OW-1:0] span_i,
    input  logic [AW-1:0] start_i,
    input  logic [IW-1:0] rdata_i,
    output logic [AW-1:0] addr_o,
    output logic          we_o,
    output logic [PW-1:0] waddr_o,
    output logic [IW-1:0] wdata_o,
    output logic          done_o
);

    logic [PW-1:0] ptr_q;

    assign we_o    = active_i && ack_i;
    assign done_o  = we_o && (OW'(ptr_q) == span_i);
    assign addr_o  = start_i + AW'(ptr_q);
    assign waddr_o = ptr_q;
    assign wdata_o = rdata_i;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            ptr_q <= '0;
        end else if (we_o) begin
            ptr_q <= done_o ? '0 : ptr_q + PW'(1);
        end
    end

    AST_WAIT_HOLDS_PTR: assert property (@(posedge clk) disable iff (rst)
        (active_i && !ack_i && !restart_i) |=> $stable(ptr_q)); // R5

endmodule

// File: rtl/lbuf_fsm.sv
module lbuf_fsm
    import lbuf_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept_i,
    input  logic     fill_done_i,
    input  logic     leave_i,
    output lb_mode_e mode_o,
    output logic     load_o,
    output logic     clear_o
);

    lb_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_NORMAL;
        else     mode_q <= lb_next_mode(mode_q, accept_i, fill_done_i, leave_i);
    end

    assign mode_o  = mode_q;
    assign load_o  = (mode_q == MODE_NORMAL) && accept_i;
    assign clear_o = (mode_q == MODE_EXEC) && leave_i;

    AST_FILL_DONE_EXEC: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_FILL && fill_done_i) |=> (mode_q == MODE_EXEC)); // R6
    AST_EXIT_TO_NORMAL: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_EXEC && leave_i) |=> (mode_q == MODE_NORMAL)); // R9

endmodule

// File: rtl/lbuf_seq_ctrl.sv
module lbuf_seq_ctrl
    import lbuf_pkg::*;
#(
    parameter int unsigned AW    = LB_ADDR_W,
    parameter int unsigned IW    = LB_INSN_W,
    parameter int unsigned DEPTH = LB_DEPTH,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned OW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          core_fetch_i,
    input  logic [AW-1:0] pc_i,
    input  logic          br_taken_i,
    input  logic [AW-1:0] br_target_i,
    input  logic          lbon_i,
    input  logic [AW-1:0] lbon_addr_i,
    input  logic [OW-1:0] lbon_offset_i,
    output logic          l1_req_o,
    output logic [AW-1:0] l1_addr_o,
    input  logic          l1_ack_i,
    input  logic [IW-1:0] l1_rdata_i,
    output logic          buf_we_o,
    output logic [PW-1:0] buf_waddr_o,
    output logic [IW-1:0] buf_wdata_o,
    output logic          buf_re_o,
    output logic [PW-1:0] buf_raddr_o,
    output logic [1:0]    mode_o
);

    lb_mode_e      mode;
    logic [AW-1:0] fetch_addr;
    logic          fits, in_win, load, clear, fill_done, leave;
    logic [AW-1:0] win_start, fill_addr;
    logic [OW-1:0] win_span;
    logic [PW-1:0] rd_idx;

    assign fetch_addr = br_taken_i ? br_target_i : pc_i;
    assign leave      = core_fetch_i && !in_win;

    lbuf_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (lbon_i && fits),
        .fill_done_i (fill_done),
        .leave_i     (leave),
        .mode_o      (mode),
        .load_o      (load),
        .clear_o     (clear)
    );

    lbuf_window #(.AW(AW), .PW(PW), .OW(OW), .DEPTH(DEPTH)) u_win (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load),
        .clear_i      (clear),
        .cmd_addr_i   (lbon_addr_i),
        .cmd_off_i    (lbon_offset_i),
        .fetch_addr_i (fetch_addr),
        .fits_o       (fits),
        .start_o      (win_start),
        .span_o       (win_span),
        .in_win_o     (in_win),
        .idx_o        (rd_idx)
    );

    lbuf_filler #(.AW(AW), .IW(IW), .PW(PW), .OW(OW)) u_fill (
        .clk       (clk),
        .rst       (rst),
        .active_i  (mode == MODE_FILL),
        .restart_i (load),
        .ack_i     (l1_ack_i),
        .span_i    (win_span),
        .start_i   (win_start),
        .rdata_i   (l1_rdata_i),
        .addr_o    (fill_addr),
        .we_o      (buf_we_o),
        .waddr_o   (buf_waddr_o),
        .wdata_o   (buf_wdata_o),
        .done_o    (fill_done)
    );

    // Source selection per phase: the core owns L1 in normal mode, the
    // filler owns it while copying, and nobody uses it while executing.
    always_comb begin
        l1_req_o    = 1'b0;
        l1_addr_o   = fetch_addr;
        buf_re_o    = 1'b0;
        buf_raddr_o = rd_idx;
        unique case (mode)
            MODE_NORMAL: l1_req_o = core_fetch_i;
            MODE_FILL: begin
                l1_req_o  = 1'b1;
                l1_addr_o = fill_addr;
            end
            MODE_EXEC:   buf_re_o = core_fetch_i && in_win;
            default:     l1_req_o = 1'b0;
        endcase
    end

    assign mode_o = mode;

    AST_BUF_XOR_L1: assert property (@(posedge clk) disable iff (rst)
        buf_re_o |-> !l1_req_o); // R7
    AST_WE_IN_FILL: assert property (@(posedge clk) disable iff (rst)
        buf_we_o |-> (mode == MODE_FILL)); // R4
    AST_REJECT_LONG: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORMAL && lbon_i && lbon_offset_i >= OW'(DEPTH)) |=> (mode == MODE_NORMAL)); // R10

endmodule

// File: tb/lbuf_seq_ctrl_tb_top.sv
module lbuf_seq_ctrl_tb_top;

    localparam int AW = 16;
    localparam int IW = 32;
    localparam int DEPTH = 128;
    localparam int PW = 7;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          core_fetch = 1'b0;
    logic [AW-1:0] pc = '0;
    logic          br_taken = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic          lbon = 1'b0;
    logic [AW-1:0] lbon_addr = '0;
    logic [OW-1:0] lbon_off = '0;
    logic          l1_req, l1_ack = 1'b0;
    logic [AW-1:0] l1_addr;
    logic [IW-1:0] l1_rdata;
    logic          buf_we, buf_re;
    logic [PW-1:0] buf_waddr, buf_raddr;
    logic [IW-1:0] buf_wdata;
    logic [1:0]    mode;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [IW-1:0] mem_word(input logic [AW-1:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    assign l1_rdata = mem_word(l1_addr);

    lbuf_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .core_fetch_i(core_fetch), .pc_i(pc),
        .br_taken_i(br_taken), .br_target_i(br_target), .lbon_i(lbon),
        .lbon_addr_i(lbon_addr), .lbon_offset_i(lbon_off),
        .l1_req_o(l1_req), .l1_addr_o(l1_addr), .l1_ack_i(l1_ack),
        .l1_rdata_i(l1_rdata), .buf_we_o(buf_we), .buf_waddr_o(buf_waddr),
        .buf_wdata_o(buf_wdata), .buf_re_o(buf_re), .buf_raddr_o(buf_raddr),
        .mode_o(mode)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) next_cycle();
        check("R1", "mode in reset", 32'(mode), 0);
        check("R1", "we in reset", 32'(buf_we), 0);
        check("R1", "re in reset", 32'(buf_re), 0);
        check("R1", "l1 req in reset", 32'(l1_req), 0);
        rst = 1'b0;
        next_cycle();
        check("R1", "mode after reset", 32'(mode), 0);
    endtask

    task automatic t_normal();
        core_fetch = 1'b1; pc = 16'h0100; br_taken = 1'b0;
        #1;
        check("R2", "l1 req", 32'(l1_req), 1);
        check("R2", "l1 addr pc", 32'(l1_addr), 32'h0100);
        check("R2", "no buf read", 32'(buf_re), 0);
        br_taken = 1'b1; br_target = 16'h0234;
        #1;
        check("R2", "l1 addr target", 32'(l1_addr), 32'h0234);
        core_fetch = 1'b0; br_taken = 1'b0;
        #1;
        check("R2", "idle no req", 32'(l1_req), 0);
        next_cycle();
    endtask

    task automatic t_reject();
        lbon = 1'b1; lbon_addr = 16'h0100; lbon_off = OW'(DEPTH);
        next_cycle();
        lbon = 1'b0;
        check("R10", "too long stays normal", 32'(mode), 0);
        lbon = 1'b1; lbon_addr = 16'hFFF0; lbon_off = 8'd20;
        next_cycle();
        lbon = 1'b0;
        check("R10", "wrap stays normal", 32'(mode), 0);
    endtask

    // Issue a start command; check the filling phase begins.
    task automatic start_loop(input logic [AW-1:0] a, input logic [OW-1:0] off);
        core_fetch = 1'b0; br_taken = 1'b0;
        lbon = 1'b1; lbon_addr = a; lbon_off = off;
        next_cycle();
        lbon = 1'b0;
        check("R3", "mode filling", 32'(mode), 1);
    endtask

    // Copy the window with optional wait states and a competing command.
    task automatic fill_loop(input logic [AW-1:0] st, input int off,
                             input bit waits, input bit inject);
        int entry = 0;
        int cyc = 0;
        while (entry <= off) begin
            l1_ack = waits ? ((cyc % 3) != 2) : 1'b1;
            lbon = inject && (cyc == 1);
            lbon_addr = 16'h0800; lbon_off = 8'd3;
            #1;
            check("R4", "fill req", 32'(l1_req), 1);
            check(inject ? "R11" : "R4", "fill addr", 32'(l1_addr), 32'(st + AW'(entry)));
            if (l1_ack) begin
                check("R4", "we", 32'(buf_we), 1);
                check("R4", "waddr", 32'(buf_waddr), 32'(entry));
                check("R4", "wdata", buf_wdata, mem_word(st + AW'(entry)));
                entry++;
            end else begin
                check("R5", "no write in wait", 32'(buf_we), 0);
            end
            next_cycle();
            cyc++;
        end
        l1_ack = 1'b0; lbon = 1'b0;
        #1;
        check("R6", "mode executing", 32'(mode), 2);
        check("R6", "no write after fill", 32'(buf_we), 0);
    endtask

    task automatic exec_hit(input string req, input logic [AW-1:0] p, input bit bt,
                            input logic [AW-1:0] tgt, input int idx);
        core_fetch = 1'b1; pc = p; br_taken = bt; br_target = tgt;
        #1;
        check(req, "buf read", 32'(buf_re), 1);
        check(req, "read idx", 32'(buf_raddr), 32'(idx));
        check(req, "no l1 req", 32'(l1_req), 0);
        next_cycle();
        check(req, "still executing", 32'(mode), 2);
    endtask

    task automatic exec_leave(input logic [AW-1:0] p, input bit bt, input logic [AW-1:0] tgt);
        logic [AW-1:0] fa;
        fa = bt ? tgt : p;
        core_fetch = 1'b1; pc = p; br_taken = bt; br_target = tgt;
        #1;
        check("R9", "no read on exit", 32'(buf_re), 0);
        check("R9", "no req on exit", 32'(l1_req), 0);
        next_cycle();
        check("R9", "back to normal", 32'(mode), 0);
        check("R9", "l1 req restart", 32'(l1_req), 1);
        check("R9", "l1 addr restart", 32'(l1_addr), 32'(fa));
        core_fetch = 1'b0; br_taken = 1'b0;
        next_cycle();
    endtask

    task automatic t_loop_main();
        start_loop(16'h0100, 8'd4);
        fill_loop(16'h0101, 4, 1'b1, 1'b1);
        exec_hit("R7", 16'h0101, 1'b0, 16'h0, 0);
        exec_hit("R7", 16'h0105, 1'b0, 16'h0, 4);
        exec_hit("R8", 16'h0105, 1'b1, 16'h0103, 2);
        core_fetch = 1'b0; pc = 16'h0300; br_taken = 1'b0;
        #1;
        check("R12", "no read idle", 32'(buf_re), 0);
        check("R12", "no req idle", 32'(l1_req), 0);
        next_cycle();
        check("R12", "still executing", 32'(mode), 2);
        lbon = 1'b1; lbon_addr = 16'h0900; lbon_off = 8'd1;
        next_cycle();
        lbon = 1'b0;
        check("R11", "cmd in exec ignored", 32'(mode), 2);
        exec_hit("R11", 16'h0102, 1'b0, 16'h0, 1);
        exec_leave(16'h0106, 1'b0, 16'h0);
    endtask

    task automatic t_loop_single();
        start_loop(16'h01FF, 8'd0);
        fill_loop(16'h0200, 0, 1'b0, 1'b0);
        exec_hit("R7", 16'h0200, 1'b0, 16'h0, 0);
        exec_leave(16'h0200, 1'b1, 16'h01FF);
    endtask

    task automatic t_loop_max();
        start_loop(16'h1000, 8'(DEPTH - 1));
        fill_loop(16'h1001, DEPTH - 1, 1'b0, 1'b0);
        exec_hit("R7", 16'h1080, 1'b0, 16'h0, DEPTH - 1);
        exec_leave(16'h1081, 1'b0, 16'h0);
    endtask

    initial begin
        t_reset();
        t_normal();
        t_reject();
        t_loop_main();
        t_loop_single();
        t_loop_max();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1600000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule